// File: doc/BRIEF.md
# Mailbox Command Bridge for Byte-Wide Controller Registers

This block lets a host reach a small bank of 8-bit controller registers through a single 64-bit command word instead of a flat address map. The host writes one word that carries a launch flag, a direction flag, an opcode, an extended register selector and a write byte. The bridge holds the word, waits a fixed number of cycles, and then performs the inner register access. For a read, it places the fetched byte in the low byte of the word. It then drops the launch flag. The host learns that the access has finished by polling that flag.

Only the extended opcode reaches the inner bank. The direct transfer opcodes (7-bit and 10-bit addressed, each with or without an internal address) and the bus clock opcode are decoded but reported as unsupported. An unsupported command still completes, but it leaves every inner register untouched and raises a sticky error flag in the word. The inner bank is a stub with a data byte, a control byte, a clock control byte and a read-only status byte. The data, control and clock control bytes also drive output ports toward the bus engine.

Top module: `mbx_cmd_bridge`

## Requirements
- R1: After reset the command word reads 0, and core_data, core_ctl and core_clkctl read 0. The status byte reads 0xF8.
- R2: Launch and completion:
  - A host write with bit 63 set, accepted while bit 63 reads 0, launches a command.
  - Bit 63 then reads 1 for exactly LATENCY cycles after the accepting edge.
  - Bit 63 clears on the LATENCY-th following edge.
  - LATENCY may be set from 1 to 4.
- R3: Extended write. A command with opcode bits 60:57 = 6 and bit 56 = 0 writes bits 7:0 at completion into the register chosen by bits 34:32: 1 selects data, 2 selects control, 3 selects clock control.
- R4: Extended read. A command with opcode 6 and bit 56 = 1 returns a byte in bits 7:0 at completion: selector 1 returns data, 2 returns control, 3 returns status. All other bits of the word, except bit 63, are kept.
- R5: Soft reset. An extended write with selector 7 sets control to 0 and status to 0xF8, and leaves data and clock control unchanged.
- R6: The following commands are unsupported:
  - any opcode other than 6;
  - selector 0, 4, 5 or 6;
  - a read with selector 7.

  An unsupported command changes no inner register and leaves bits 7:0 unchanged. It sets bit 62 at completion.
- R7: Bit 62 is sticky. It holds until the next accepted host write. Bit 62 of an accepted host word is ignored and stored as 0.
- R8: A host write while bit 63 reads 1 is ignored. The in-flight command and its result are those of the first word.
- R9: A host write with bit 63 clear while idle is stored as the command word and launches nothing. No inner register changes and the word stays as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| cmd_word | output | 64 | Current command word as read back by the host |
| core_data | output | 8 | Inner data register |
| core_ctl | output | 8 | Inner control register |
| core_clkctl | output | 8 | Inner clock control register |

## Verification
The bench sweeps every opcode and every selector in both directions and compares each completed word and each inner register with a model. A design that decodes the selector with the wrong direction gives itself away here: it returns clock control instead of status on a read, or it writes on an unsupported read with selector 7. A second write is sent in the cycle after a launch. A bridge that does not lock the word while busy returns the wrong byte or writes the wrong register. Further cases cover the following:
- the sticky error flag, which must persist across idle cycles and clear on the next write;
- a host word with bit 62 already set, which must be stored with bit 62 at 0;
- an idle write without the launch flag, which must not touch the bank.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int VALID_BIT = 63;
    localparam int ERR_BIT   = 62;
    localparam int OP_HI     = 60;
    localparam int OP_LO     = 57;
    localparam int READ_BIT  = 56;
    localparam int SEL_HI    = 34;
    localparam int SEL_LO    = 32;

    localparam logic [7:0] STAT_IDLE = 8'hF8;

    typedef enum logic [2:0] {
        K_XFER7    = 3'd0,
        K_XFER7_IA = 3'd1,
        K_XFER10   = 3'd2,
        K_XFER10IA = 3'd3,
        K_BUSCLK   = 3'd4,
        K_EXT      = 3'd5,
        K_BAD      = 3'd6
    } op_kind_e;

    typedef enum logic [2:0] {
        S_NONE  = 3'd0,
        S_DATA  = 3'd1,
        S_CTL   = 3'd2,
        S_CLK   = 3'd3,
        S_STAT  = 3'd4,
        S_RESET = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [63:0] word,
    output op_kind_e    kind,
    output reg_sel_e    sel,
    output logic        is_read,
    output logic        supported
);
    logic [3:0] op;
    logic [2:0] xsel;

    always_comb begin
        op      = word[OP_HI:OP_LO];
        xsel    = word[SEL_HI:SEL_LO];
        is_read = word[READ_BIT];
        unique case (op)
            4'd0:    kind = K_XFER7;
            4'd1:    kind = K_XFER7_IA;
            4'd2:    kind = K_XFER10;
            4'd3:    kind = K_XFER10IA;
            4'd4:    kind = K_BUSCLK;
            4'd6:    kind = K_EXT;
            default: kind = K_BAD;
        endcase
        sel = S_NONE;
        if (kind == K_EXT) begin
            unique case (xsel)
                3'd1:    sel = S_DATA;
                3'd2:    sel = S_CTL;
                3'd3:    sel = is_read ? S_STAT : S_CLK;
                3'd7:    sel = is_read ? S_NONE : S_RESET;
                default: sel = S_NONE;
            endcase
        end
        supported = (sel != S_NONE);
    end
endmodule

// File: rtl/mbx_regbank.sv
module mbx_regbank
    import mbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] data_o,
    output logic [DW-1:0] ctl_o,
    output logic [DW-1:0] clk_o
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] ctl;
        logic [DW-1:0] clkc;
        logic [DW-1:0] stat;
    } bank_t;

    bank_t bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            unique case (sel)
                S_DATA:  bank_d.data = wdata;
                S_CTL:   bank_d.ctl  = wdata;
                S_CLK:   bank_d.clkc = wdata;
                S_RESET: begin
                    bank_d.ctl  = '0;
                    bank_d.stat = DW'(STAT_IDLE);
                end
                default: ;
            endcase
        end
        unique case (sel)
            S_DATA:  rdata = bank_q.data;
            S_CTL:   rdata = bank_q.ctl;
            S_STAT:  rdata = bank_q.stat;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q      <= '0;
            bank_q.stat <= DW'(STAT_IDLE);
        end else begin
            bank_q <= bank_d;
        end
    end

    assign data_o = bank_q.data;
    assign ctl_o  = bank_q.ctl;
    assign clk_o  = bank_q.clkc;

    assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == S_RESET) |=> (bank_q.ctl == '0 && bank_q.stat == DW'(STAT_IDLE)));

    assert_reset_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == S_RESET) |=> ($stable(bank_q.data) && $stable(bank_q.clkc)));
endmodule

// File: rtl/mbx_cmd_bridge.sv
module mbx_cmd_bridge
    import mbx_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [63:0] host_wdata,
    output logic [63:0] cmd_word,
    output logic [7:0]  core_data,
    output logic [7:0]  core_ctl,
    output logic [7:0]  core_clkctl
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    typedef struct packed {
        logic [63:0]      word;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    op_kind_e   kind;
    reg_sel_e   sel;
    logic       is_read;
    logic       supported;
    logic       done;
    logic       bank_we;
    logic [7:0] bank_rdata;

    mbx_decode u_decode (
        .word      (st_q.word),
        .kind      (kind),
        .sel       (sel),
        .is_read   (is_read),
        .supported (supported)
    );

    mbx_regbank #(.DW(8)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bank_we),
        .sel    (sel),
        .wdata  (st_q.word[7:0]),
        .rdata  (bank_rdata),
        .data_o (core_data),
        .ctl_o  (core_ctl),
        .clk_o  (core_clkctl)
    );

    always_comb begin
        st_d    = st_q;
        done    = st_q.word[VALID_BIT] && (st_q.cnt == '0);
        bank_we = done && supported && !is_read;
        if (!st_q.word[VALID_BIT]) begin
            if (host_wr) begin
                st_d.word          = host_wdata;
                st_d.word[ERR_BIT] = 1'b0;
                st_d.cnt           = CNT_LOAD;
            end
        end else if (!done) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.word[VALID_BIT] = 1'b0;
            if (!supported) begin
                st_d.word[ERR_BIT] = 1'b1;
            end else if (is_read) begin
                st_d.word[7:0] = bank_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_word = st_q.word;

    assert_busy_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.word[VALID_BIT] && st_q.cnt != '0) |=> $stable(st_q.word));

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LOAD);

    assert_launch_from_host_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.word[VALID_BIT]) |-> $past(host_wr));

    assert_finish_after_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.word[VALID_BIT]) |-> $past(st_q.cnt) == '0);

    assert_error_no_touch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.word[ERR_BIT]) |->
            ($stable(core_ctl) && $stable(core_clkctl) && $stable(core_data)));

    assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.word[VALID_BIT] && !host_wr) |=> $stable(st_q.word));
endmodule

// File: tb/mbx_cmd_bridge_tb.sv
module mbx_cmd_bridge_tb;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] cmd_word;
    logic [7:0]  core_data, core_ctl, core_clkctl;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] m_data = 8'h00, m_ctl = 8'h00, m_clk = 8'h00, m_stat = 8'hF8;

    always #5 clk = ~clk;

    mbx_cmd_bridge #(.LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .cmd_word(cmd_word), .core_data(core_data), .core_ctl(core_ctl),
        .core_clkctl(core_clkctl)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit v, input bit e, input int op,
                                       input bit rd, input int sel, input logic [7:0] b);
        logic [63:0] w;
        w = 64'h0000_5A00_0000_3C00;
        w[63] = v; w[62] = e; w[60:57] = op[3:0]; w[56] = rd;
        w[34:32] = sel[2:0]; w[7:0] = b;
        return w;
    endfunction

    task automatic pulse(input logic [63:0] w);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic check_bank(input string req);
        chk(req, {56'd0, core_data},   {56'd0, m_data});
        chk(req, {56'd0, core_ctl},    {56'd0, m_ctl});
        chk(req, {56'd0, core_clkctl}, {56'd0, m_clk});
    endtask

    // Launch a command and check it against the model at completion.
    task automatic run_cmd(input logic [63:0] w, input string req);
        logic [63:0] exp;
        bit ok, rd;
        int op, sel;
        op = int'(w[60:57]); rd = w[56]; sel = int'(w[34:32]);
        ok = (op == 6) && ((sel >= 1 && sel <= 3) || (sel == 7 && !rd));
        pulse(w);
        chk("R2 valid held", {63'd0, cmd_word[63]}, 64'd1);
        chk("R7 host bit62 ignored", {63'd0, cmd_word[62]}, 64'd0);
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            chk("R2 valid held", {63'd0, cmd_word[63]}, 64'd1);
        end
        @(negedge clk);
        exp = w; exp[63] = 1'b0; exp[62] = 1'b0;
        if (!ok) begin
            exp[62] = 1'b1;
        end else if (rd) begin
            exp[7:0] = (sel == 1) ? m_data : (sel == 2) ? m_ctl : m_stat;
        end else begin
            if (sel == 1) m_data = w[7:0];
            if (sel == 2) m_ctl  = w[7:0];
            if (sel == 3) m_clk  = w[7:0];
            if (sel == 7) begin m_ctl = 8'h00; m_stat = 8'hF8; end
        end
        chk(req, cmd_word, exp);
        check_bank(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 word after reset", cmd_word, 64'd0);
        check_bank("R1 bank after reset");

        // R4 status reads idle after reset
        run_cmd(mk(1, 0, 6, 1, 3, 8'h11), "R4 status read");

        // R3/R4/R5/R6 sweep of direction, opcode and selector
        for (int rd = 0; rd < 2; rd++) begin
            for (int op = 0; op < 8; op++) begin
                for (int sel = 0; sel < 8; sel++) begin
                    logic [7:0] b;
                    b = 8'((op * 37 + sel * 11 + rd * 5 + 3) & 255);
                    run_cmd(mk(1, ((op + sel) % 3) == 0, op, rd[0], sel, b),
                            (op == 6) ? "R3 R4 R5 extended" : "R6 unsupported");
                end
            end
        end

        // R5 explicit soft reset after control and clock control are nonzero
        run_cmd(mk(1, 0, 6, 0, 2, 8'hA5), "R3 ctl write");
        run_cmd(mk(1, 0, 6, 0, 3, 8'h3C), "R3 clkctl write");
        run_cmd(mk(1, 0, 6, 0, 7, 8'h77), "R5 soft reset");
        run_cmd(mk(1, 0, 6, 1, 2, 8'h00), "R5 ctl read after reset");

        // R7 sticky error flag
        run_cmd(mk(1, 0, 2, 0, 1, 8'h42), "R6 xfer opcode");
        repeat (5) @(negedge clk);
        chk("R7 error sticky", {63'd0, cmd_word[62]}, 64'd1);
        run_cmd(mk(1, 0, 6, 1, 1, 8'h00), "R7 cleared by next write");

        // R8 write while busy is ignored
        begin
            logic [63:0] w1, w2, exp;
            w1 = mk(1, 0, 6, 0, 1, 8'hC3);
            w2 = mk(1, 0, 6, 0, 2, 8'h99);
            pulse(w1);
            host_wr = 1'b1; host_wdata = w2;
            @(negedge clk);
            host_wr = 1'b0;
            repeat (LAT - 1) @(negedge clk);
            m_data = 8'hC3;
            exp = w1; exp[63] = 1'b0;
            chk("R8 busy write ignored", cmd_word, exp);
            check_bank("R8 busy write ignored");
        end

        // R9 idle write without launch flag
        begin
            logic [63:0] w;
            w = mk(0, 1, 6, 0, 2, 8'h5E);
            pulse(w);
            repeat (LAT + 2) @(negedge clk);
            w[62] = 1'b0;
            chk("R9 stored no launch", cmd_word, w);
            check_bank("R9 no inner access");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule